// File: doc/BRIEF.md
# Seeded Test Signal Source Selector

This block makes the sample stream for one digitiser input path. A select field picks one of several sources: fixed zero, fixed one, the live converter sample, a seeded pseudo-random noise generator, a programmable-frequency tone, or that noise with a quarter-amplitude copy of the tone added. The chosen value is registered and presented one clock later as a signed sample.

The noise generator is a 32-bit linear feedback shift register. Its seed is a 4-bit nibble extended by a fixed non-zero tail that is set per instance, so inputs given equal or different nibbles produce correlated or uncorrelated noise. A rising edge on the arm input loads the seed, and the generator then waits for the next frame sync pulse before it runs. Separate boards that are armed before a shared sync therefore produce identical sequences. The tone comes from a phase accumulator followed by a parabolic sine approximation.

Top module: `test_src_select`

## Requirements
- R1: While reset is low and on the first sample after it, `sample_out` is 0 and the noise generator is idle.
- R2: Select codes: 0 gives 0, 1 gives +1, 6 and 7 give 0. Codes 2, 3, 4 and 5 give the converter sample, the noise, the tone and the mix.
- R3: With code 3, after a sync pulse has started the generator, the noise is the low `SAMPLE_W` bits of the state, read as signed. In the sync cycle the state is set to `{seed_nib, SEED_TAIL}` and does not step. On each later clock it steps once: the state shifts right by one, and if the bit shifted out was 1 it is XORed with 0x80200003.
- R4: The noise output is 0 from an arm edge until the generator starts. Holding `arm` high causes no further reload.
- R5: When an arm rising edge and a sync pulse fall in the same cycle, the arm takes effect and the generator waits for a later sync.
- R6: The phase register resets to 0 and adds `tone_freq << (PHASE_W-13)` every clock, modulo 2^PHASE_W. Take x as the `SAMPLE_W` bits below the phase MSB. The magnitude is min(x*(2^SAMPLE_W - x) >> (SAMPLE_W-1), 2^(SAMPLE_W-1)-1), and it is negated when the phase MSB is 1.
- R7: Code 5 gives noise + (tone >>> 2), saturated to the signed `SAMPLE_W` range rather than wrapping.
- R8: `sample_out` shows the value selected by the inputs and state of the previous clock, one register stage.
- R9: An arm edge while the generator runs stops it, reloads the seed and holds the output at 0 until the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 3 | Source select code |
| adc_sample | input | SAMPLE_W | Live converter sample, signed |
| tone_freq | input | 12 | Tone frequency word |
| seed_nib | input | 4 | Noise seed nibble |
| arm | input | 1 | Noise arm level; a rising edge arms |
| sync_pulse | input | 1 | Frame sync pulse, one cycle |
| sample_out | output | SAMPLE_W | Registered output sample, signed |

## Verification
The bench builds the block with SAMPLE_W = 8, PHASE_W = 16 and the default seed tail. With an 8-bit sample, noise near full scale plus a slow tone near its peak overflows often, so the saturation paths of the mix are reached within a few hundred cycles. A 16-bit phase with the top frequency code covers a half-cycle-per-sample step and its wrap. A reference model of the shift register and the phase accumulator, run in step with every clock, checks the arm and sync orderings cycle by cycle.

// File: rtl/tss_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the test signal source selector.
// Assumes a 32-bit noise state and a 12-bit tone frequency word.
package tss_pkg;
    localparam int FREQ_W     = 12;
    localparam int SEED_NIB_W = 4;
    localparam int GEN_W      = 32;
    localparam int TAIL_W     = GEN_W - SEED_NIB_W;
    localparam logic [GEN_W-1:0] LFSR_TAPS = 32'h8020_0003;

    typedef enum logic [2:0] {
        SEL_ZERO  = 3'd0,
        SEL_ONE   = 3'd1,
        SEL_ADC   = 3'd2,
        SEL_NOISE = 3'd3,
        SEL_TONE  = 3'd4,
        SEL_MIX   = 3'd5
    } src_sel_e;

    // One Galois step, shifting right.
    function automatic logic [GEN_W-1:0] lfsr_next(input logic [GEN_W-1:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
    endfunction
endpackage

// File: rtl/tss_noise.sv
`timescale 1ns/1ps
// Seeded noise generator. An arm rising edge loads {seed_nib, SEED_TAIL}.
// The generator starts on the next sync pulse and then steps every clock.
// The output is zero while the generator is not running. Assumes SAMPLE_W <= 32.
module tss_noise
    import tss_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter logic [TAIL_W-1:0] SEED_TAIL = 28'h5A3_C96E
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       arm,
    input  logic                       sync_pulse,
    input  logic [SEED_NIB_W-1:0]      seed_nib,
    output logic signed [SAMPLE_W-1:0] noise_out,
    output logic                       running,
    output logic                       pending,
    output logic                       arm_q
);
    logic [GEN_W-1:0] state;
    logic             arm_rise;

    // Rising-edge detect on the arm level.
    assign arm_rise = arm && !arm_q;

    // Arm, wait-for-sync and run sequencing, with the register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q   <= 1'b0;
            pending <= 1'b0;
            running <= 1'b0;
            state   <= {{SEED_NIB_W{1'b0}}, SEED_TAIL};
        end else begin
            arm_q <= arm;
            if (arm_rise) begin
                state   <= {seed_nib, SEED_TAIL};
                pending <= 1'b1;
                running <= 1'b0;
            end else if (pending && sync_pulse) begin
                pending <= 1'b0;
                running <= 1'b1;
            end else if (running) begin
                state <= lfsr_next(state);
            end
        end
    end

    // Output the low state bits only while the generator runs.
    assign noise_out = running ? $signed(state[SAMPLE_W-1:0]) : '0;
endmodule

// File: rtl/tss_tone.sv
`timescale 1ns/1ps
// Tone generator: a phase accumulator followed by a parabolic sine shape.
// The top frequency code steps half a cycle per sample.
// Assumes PHASE_W >= 13 and PHASE_W - 1 >= SAMPLE_W.
module tss_tone
    import tss_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int PHASE_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [FREQ_W-1:0]          tone_freq,
    output logic signed [SAMPLE_W-1:0] tone_out
);
    localparam int SHIFT = PHASE_W - (FREQ_W + 1);
    localparam int PW    = 2 * SAMPLE_W + 2;
    localparam logic [PW-1:0] FULL = PW'(1) << SAMPLE_W;
    localparam logic [PW-1:0] MAXP = (PW'(1) << (SAMPLE_W - 1)) - PW'(1);

    logic [PHASE_W-1:0]  phase;
    logic [PHASE_W-1:0]  step;
    logic [SAMPLE_W-1:0] x;
    logic [PW-1:0]       prod;
    logic [PW-1:0]       mag_w;
    logic [SAMPLE_W-1:0] mag;

    assign step = PHASE_W'(tone_freq) << SHIFT;

    // Advance the phase by the frequency step every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + step;
    end

    // Parabolic half-wave magnitude, clamped, with the sign from the phase MSB.
    always_comb begin
        x        = phase[PHASE_W-2 -: SAMPLE_W];
        prod     = PW'(x) * (FULL - PW'(x));
        mag_w    = prod >> (SAMPLE_W - 1);
        mag      = (mag_w > MAXP) ? MAXP[SAMPLE_W-1:0] : mag_w[SAMPLE_W-1:0];
        tone_out = phase[PHASE_W-1] ? -$signed(mag) : $signed(mag);
    end
endmodule

// File: rtl/test_src_select.sv
`timescale 1ns/1ps
// Test signal source selector for one input path. It picks zero, one, the
// converter sample, noise, tone or the saturated noise+tone/4 mix, and registers it.
module test_src_select
    import tss_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int PHASE_W  = 16,
    parameter logic [TAIL_W-1:0] SEED_TAIL = 28'h5A3_C96E
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          src_sel,
    input  logic [SAMPLE_W-1:0] adc_sample,
    input  logic [11:0]         tone_freq,
    input  logic [3:0]          seed_nib,
    input  logic                arm,
    input  logic                sync_pulse,
    output logic [SAMPLE_W-1:0] sample_out
);
    localparam logic [SAMPLE_W-1:0] POS_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] NEG_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic signed [SAMPLE_W-1:0] noise_val;
    logic signed [SAMPLE_W-1:0] tone_val;
    logic signed [SAMPLE_W-1:0] tone_q;
    logic        [SAMPLE_W:0]   mix_sum;
    logic        [SAMPLE_W-1:0] mix_sat;
    logic        [SAMPLE_W-1:0] sel_val;
    logic                       noise_running;
    logic                       noise_pending;
    logic                       arm_prev;

    tss_noise #(.SAMPLE_W(SAMPLE_W), .SEED_TAIL(SEED_TAIL)) u_noise (
        .clk(clk), .rst_n(rst_n), .arm(arm), .sync_pulse(sync_pulse),
        .seed_nib(seed_nib), .noise_out(noise_val), .running(noise_running),
        .pending(noise_pending), .arm_q(arm_prev)
    );

    tss_tone #(.SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W)) u_tone (
        .clk(clk), .rst_n(rst_n), .tone_freq(tone_freq), .tone_out(tone_val)
    );

    // Noise plus a quarter tone, saturated on overflow.
    always_comb begin
        tone_q  = tone_val >>> 2;
        mix_sum = {noise_val[SAMPLE_W-1], noise_val} + {tone_q[SAMPLE_W-1], tone_q};
        if (mix_sum[SAMPLE_W] != mix_sum[SAMPLE_W-1])
            mix_sat = mix_sum[SAMPLE_W] ? NEG_MIN : POS_MAX;
        else
            mix_sat = mix_sum[SAMPLE_W-1:0];
    end

    // Source multiplexer; unused codes give zero.
    always_comb begin
        case (src_sel)
            SEL_ONE:   sel_val = SAMPLE_W'(1);
            SEL_ADC:   sel_val = adc_sample;
            SEL_NOISE: sel_val = noise_val;
            SEL_TONE:  sel_val = tone_val;
            SEL_MIX:   sel_val = mix_sat;
            default:   sel_val = '0;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) sample_out <= '0;
        else        sample_out <= sel_val;
    end
endmodule

// File: rtl/tss_checker.sv
`timescale 1ns/1ps
// Protocol checks for test_src_select, attached with bind.
module tss_checker #(
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          src_sel,
    input logic [SAMPLE_W-1:0] adc_sample,
    input logic                arm,
    input logic                sync_pulse,
    input logic [SAMPLE_W-1:0] sample_out,
    input logic                noise_run,
    input logic                noise_pend,
    input logic                arm_seen
);
    AST_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd0 || src_sel == 3'd6 || src_sel == 3'd7) |=> sample_out == '0); // R2
    AST_SEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd1) |=> sample_out == SAMPLE_W'(1)); // R2
    AST_ADC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd2) |=> sample_out == $past(adc_sample)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 3'd3 && !noise_run) |=> sample_out == '0); // R4
    AST_ARM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !arm_seen) |=> (!noise_run && noise_pend)); // R5
    AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_pend && sync_pulse && !(arm && !arm_seen)) |=> noise_run); // R3
endmodule

bind test_src_select tss_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .adc_sample(adc_sample),
    .arm(arm), .sync_pulse(sync_pulse), .sample_out(sample_out),
    .noise_run(noise_running), .noise_pend(noise_pending), .arm_seen(arm_prev)
);

// File: tb/test_src_select_bench.sv
`timescale 1ns/1ps
// Directed bench with a cycle-level reference model of noise and tone.
module test_src_select_bench;
    localparam int SW = 8;
    localparam int PW = 16;
    localparam logic [27:0] TAIL = 28'h5A3_C96E;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    src_sel = 3'd0;
    logic [SW-1:0] adc_sample = '0;
    logic [11:0]   tone_freq = '0;
    logic [3:0]    seed_nib = '0;
    logic          arm = 1'b0;
    logic          sync_pulse = 1'b0;
    logic [SW-1:0] sample_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [31:0] m_lfsr = '0;
    bit          m_run = 1'b0;
    bit          m_pend = 1'b0;
    bit          m_arm_q = 1'b0;
    int          m_phase = 0;
    int          sat_hits = 0;

    test_src_select #(.SAMPLE_W(SW), .PHASE_W(PW), .SEED_TAIL(TAIL)) u_test_src_select (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .adc_sample(adc_sample),
        .tone_freq(tone_freq), .seed_nib(seed_nib), .arm(arm),
        .sync_pulse(sync_pulse), .sample_out(sample_out)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int tone_of(input int ph);
        int x, mag;
        x = (ph >> 7) & 255;
        mag = (x * (256 - x)) >> 7;
        if (mag > 127) mag = 127;
        return ((ph >> 15) & 1) ? -mag : mag;
    endfunction

    function automatic int noise_of();
        int n;
        if (!m_run) return 0;
        n = int'(m_lfsr[7:0]);
        return (n > 127) ? n - 256 : n;
    endfunction

    function automatic int expect_now();
        int s, a;
        a = int'(adc_sample);
        if (a > 127) a -= 256;
        case (src_sel)
            3'd1: return 1;
            3'd2: return a;
            3'd3: return noise_of();
            3'd4: return tone_of(m_phase);
            3'd5: begin
                s = noise_of() + (tone_of(m_phase) >>> 2);
                if (s > 127) begin s = 127; sat_hits++; end
                if (s < -128) begin s = -128; sat_hits++; end
                return s;
            end
            default: return 0;
        endcase
    endfunction

    // One clock: predict, advance the model, then compare after the edge.
    task automatic step(input string tag);
        int e;
        bit rise;
        e = expect_now();
        rise = arm && !m_arm_q;
        m_arm_q = arm;
        if (rise) begin
            m_lfsr = {seed_nib, TAIL}; m_pend = 1; m_run = 0;
        end else if (m_pend && sync_pulse) begin
            m_pend = 0; m_run = 1;
        end else if (m_run) begin
            m_lfsr = m_lfsr[0] ? ((m_lfsr >> 1) ^ 32'h8020_0003) : (m_lfsr >> 1);
        end
        m_phase = (m_phase + (int'(tone_freq) << 3)) & 16'hFFFF;
        @(posedge clk);
        @(negedge clk);
        check(tag, $signed(sample_out), e);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 in reset", $signed(sample_out), 0);
        src_sel = 3'd3;
        rst_n = 1'b1;
        step("R1 first sample");
        step("R1 noise idle");
    endtask

    task automatic t_consts();
        adc_sample = 8'h5A;
        src_sel = 3'd0; step("R2 code0");
        src_sel = 3'd1; step("R2 code1");
        src_sel = 3'd6; step("R2 code6");
        src_sel = 3'd7; step("R2 code7");
        src_sel = 3'd2;
        for (int i = 0; i < 6; i++) begin
            adc_sample = SW'(i * 47 + 130);
            step("R8 adc latency");
        end
    endtask

    task automatic t_tone();
        src_sel = 3'd4;
        tone_freq = 12'd4095;
        for (int i = 0; i < 20; i++) step("R6 top freq");
        tone_freq = 12'd173;
        for (int i = 0; i < 60; i++) step("R6 mid freq");
    endtask

    task automatic t_noise();
        src_sel = 3'd3; seed_nib = 4'h5; arm = 1'b1;
        for (int i = 0; i < 5; i++) step("R4 armed idle");
        sync_pulse = 1'b1; step("R3 sync start");
        sync_pulse = 1'b0;
        for (int i = 0; i < 40; i++) step("R3 noise run");
        sync_pulse = 1'b1; step("R4 held arm no reload");
        sync_pulse = 1'b0;
        for (int i = 0; i < 10; i++) step("R4 continues");
    endtask

    task automatic t_same_cycle();
        arm = 1'b0; step("R5 setup");
        arm = 1'b1; sync_pulse = 1'b1; seed_nib = 4'hC; step("R5 arm with sync");
        sync_pulse = 1'b0;
        for (int i = 0; i < 4; i++) step("R5 still waiting");
        sync_pulse = 1'b1; step("R5 later sync");
        sync_pulse = 1'b0;
        for (int i = 0; i < 10; i++) step("R5 running");
    endtask

    task automatic t_rearm();
        arm = 1'b0; step("R9 drop arm");
        arm = 1'b1; seed_nib = 4'hA; step("R9 rearm edge");
        for (int i = 0; i < 5; i++) step("R9 zero until sync");
        sync_pulse = 1'b1; step("R9 sync");
        sync_pulse = 1'b0;
        for (int i = 0; i < 20; i++) step("R9 new sequence");
    endtask

    task automatic t_mix();
        src_sel = 3'd5; tone_freq = 12'd3;
        sat_hits = 0;
        for (int i = 0; i < 400; i++) step("R7 mix");
        check("R7 saturation reached", int'(sat_hits > 0), 1);
    endtask

    initial begin
        t_reset();
        t_consts();
        t_tone();
        t_noise();
        t_same_cycle();
        t_rearm();
        t_mix();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule